// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It runs the start-up sequence the memory needs before normal traffic. After reset it holds the clock enable low for a programmable stabilization wait. It then raises the clock enable with a NOP and issues a fixed series of commands on the chip-select, row-strobe, column-strobe and write-enable lines, together with the bank-address and address buses. Every command is separated from the next by the minimum gap that command requires, and NOPs fill all idle cycles.

The series first precharges every bank and writes the extended register so that the delay-locked loop turns on. It then resets the loop through the mode register, precharges again and performs a programmable number of auto refreshes. A last mode-register write installs the operating mode. The done flag rises once that last write has had its settling gap and the loop-lock window, measured from the loop reset, has run out. Reads are allowed only after that point.

All waits are parameters counted in clock cycles. The stabilization wait defaults to 200 µs at 100 MHz, and a bench can shorten it. The operating mode word and the extended word are taken from inputs.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and for T_STABLE cycles after it falls (cycles 0 to T_STABLE-1), `cke` is 0, `init_done` is 0 and the command is NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111, `ba` = 0, `addr` = 0).
- R2: In cycle T_STABLE, `cke` rises while the command is NOP. It then stays 1 until the next reset.
- R3: Commands come in a fixed order, with no other command between them. Precharge-all comes at cycle T_STABLE+1. The extended write follows T_RP cycles later. The loop-reset mode write follows T_MRD cycles after that, and a second precharge-all follows T_MRD cycles later. The first refresh follows T_RP cycles after that. The final mode write comes T_RFC cycles after the last refresh. Two mode-register writes are never closer than T_MRD cycles.
- R4: A precharge-all is code 4'b0010 with `addr[10]` = 1 and every other address bit and `ba` at 0.
- R5: The extended write is code 4'b0000 with `ba` = 2'b01 and `addr[0]` = 0 (loop enabled). `addr[1]` is copied from `ext_word[1]` (drive strength), and all other address bits are 0 whatever `ext_word` holds.
- R6: The loop-reset mode write is code 4'b0000 with `ba` = 2'b00, `addr[8]` = 1 and `addr[7]` = 0. All other bits are copied from `mode_word`.
- R7: There are exactly N_REF auto refreshes, each coded 4'b0001 with `ba` and `addr` at 0, spaced T_RFC cycles apart.
- R8: The final mode write is code 4'b0000 with `ba` = 2'b00, `addr[8]` = 0 and `addr[7]` = 0. All other bits are copied from `mode_word`.
- R9: Every cycle after cycle T_STABLE that carries none of the commands above is a NOP with `ba` and `addr` at 0.
- R10: `init_done` rises in cycle max(final write + T_MRD, loop-reset write + T_DLL_LOCK). It stays 1 until reset, and only NOPs are issued from then on.
- R11: A reset at any point in the sequence restarts it from the R1 state, with the same timing as from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | ADDR_W | Operating mode for the mode writes; bits 8 and 7 are overridden |
| ext_word | input | ADDR_W | Extended word; only bit 1 (drive strength) is used |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete, reads allowed |

## Verification
The command bus is decoded from registered state, so each command appears in the cycle that starts when the edge it was scheduled for has passed. Cycle k is counted as the number of rising edges with reset low. The stabilization wait covers cycles 0 to T_STABLE-1, the first precharge is due at T_STABLE+1, and each later command is due at the previous one plus that command's gap. The done flag is due at the larger of the final write plus T_MRD and the loop-reset write plus T_DLL_LOCK. The bench computes these cycle numbers from the parameters and samples every output at the falling edge of each cycle. Two instances are checked: in one the lock window decides when done rises, and in the other the final write's gap decides it.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    localparam int BA_W       = 2;
    localparam int BIT_DRV    = 1;
    localparam int BIT_TEST   = 7;
    localparam int BIT_DLLRST = 8;
    localparam int BIT_AP     = 10;

    // Command code, bit order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PALL = 4'b0010,
        CMD_NOP  = 4'b0111
    } cmd_t;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_CKE,
        ST_PALL1,
        ST_EXT,
        ST_DLLRST,
        ST_PALL2,
        ST_REF,
        ST_MODE,
        ST_LOCK,
        ST_DONE
    } step_t;

    typedef struct packed {
        cmd_t            cmd;
        logic [BA_W-1:0] ba;
    } cmd_head_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
    parameter int T_DLL_LOCK = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic lock_ok
);
    localparam int LW = $clog2(T_DLL_LOCK + 1);

    logic          armed;
    logic [LW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (start) begin
            armed <= 1'b1;
            left  <= LW'(T_DLL_LOCK - 1);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign lock_ok = armed && (left == '0);

    // R10: the lock window is never already complete right after it starts
    assert_lock_not_instant_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> !lock_ok);
endmodule

// File: rtl/ddr_init_cmdgen.sv
module ddr_init_cmdgen
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  step_t             step,
    input  logic              fresh,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [ADDR_W-1:0] ext_word,
    output cmd_head_t         head,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] M_AP      = ONE << BIT_AP;
    localparam logic [ADDR_W-1:0] M_DRV     = ONE << BIT_DRV;
    localparam logic [ADDR_W-1:0] M_DLLRST  = ONE << BIT_DLLRST;
    localparam logic [ADDR_W-1:0] M_CLEAR   = (ONE << BIT_DLLRST) | (ONE << BIT_TEST);

    logic [ADDR_W-1:0] mode_base;
    assign mode_base = mode_word & ~M_CLEAR;

    always_comb begin
        head.cmd = CMD_NOP;
        head.ba  = '0;
        addr     = '0;
        if (fresh) begin
            unique case (step)
                ST_PALL1, ST_PALL2: begin
                    head.cmd = CMD_PALL;
                    addr     = M_AP;
                end
                ST_EXT: begin
                    head.cmd = CMD_MODE;
                    head.ba  = BA_W'(1);
                    addr     = ext_word & M_DRV;
                end
                ST_DLLRST: begin
                    head.cmd = CMD_MODE;
                    addr     = mode_base | M_DLLRST;
                end
                ST_REF:  head.cmd = CMD_REF;
                ST_MODE: begin
                    head.cmd = CMD_MODE;
                    addr     = mode_base;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int T_STABLE   = 20000,
    parameter int T_RP       = 2,
    parameter int T_RFC      = 8,
    parameter int T_MRD      = 2,
    parameter int N_REF      = 2,
    parameter int T_DLL_LOCK = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [ADDR_W-1:0] ext_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int MAX_GAP = max_of(max_of(T_STABLE, T_RP), max_of(T_RFC, T_MRD));
    localparam int CNT_W   = $clog2(MAX_GAP + 1);
    localparam int REF_W   = $clog2(N_REF + 1);
    localparam int SP_W    = $clog2(T_MRD + 1) + 1;

    step_t             step, step_nxt;
    logic              fresh;
    logic              cke_q;
    logic [REF_W-1:0]  ref_cnt, ref_nxt;
    logic              t_zero, t_load;
    logic [CNT_W-1:0]  t_val;
    logic              lock_ok;
    logic              lock_start;
    cmd_head_t         head;

    ddr_init_timer #(.W(CNT_W), .RST_VAL(T_STABLE - 1)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    assign lock_start = (step == ST_DLLRST) && fresh;

    ddr_init_lock #(.T_DLL_LOCK(T_DLL_LOCK)) u_lock (
        .clk(clk), .rst(rst), .start(lock_start), .lock_ok(lock_ok)
    );

    ddr_init_cmdgen #(.ADDR_W(ADDR_W)) u_cmdgen (
        .step(step), .fresh(fresh), .mode_word(mode_word), .ext_word(ext_word),
        .head(head), .addr(addr)
    );

    always_comb begin
        step_nxt = step;
        ref_nxt  = ref_cnt;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (step)
            ST_WAIT: if (t_zero) begin
                step_nxt = ST_CKE;   t_load = 1'b1; t_val = '0;
            end
            ST_CKE: if (t_zero) begin
                step_nxt = ST_PALL1; t_load = 1'b1; t_val = CNT_W'(T_RP - 1);
            end
            ST_PALL1: if (t_zero) begin
                step_nxt = ST_EXT;   t_load = 1'b1; t_val = CNT_W'(T_MRD - 1);
            end
            ST_EXT: if (t_zero) begin
                step_nxt = ST_DLLRST; t_load = 1'b1; t_val = CNT_W'(T_MRD - 1);
            end
            ST_DLLRST: if (t_zero) begin
                step_nxt = ST_PALL2; t_load = 1'b1; t_val = CNT_W'(T_RP - 1);
            end
            ST_PALL2: if (t_zero) begin
                step_nxt = ST_REF;   t_load = 1'b1; t_val = CNT_W'(T_RFC - 1);
                ref_nxt  = '0;
            end
            ST_REF: if (t_zero) begin
                t_load = 1'b1;
                if (ref_cnt == REF_W'(N_REF - 1)) begin
                    step_nxt = ST_MODE; t_val = CNT_W'(T_MRD - 1);
                end else begin
                    ref_nxt = ref_cnt + 1'b1; t_val = CNT_W'(T_RFC - 1);
                end
            end
            ST_MODE: if (t_zero) step_nxt = ST_LOCK;
            ST_LOCK: if (lock_ok) step_nxt = ST_DONE;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= ST_WAIT;
            fresh   <= 1'b0;
            cke_q   <= 1'b0;
            ref_cnt <= '0;
        end else begin
            step    <= step_nxt;
            fresh   <= t_load;
            ref_cnt <= ref_nxt;
            if (step == ST_WAIT && t_zero)
                cke_q <= 1'b1;
        end
    end

    assign cke       = cke_q;
    assign {cs_n, ras_n, cas_n, we_n} = head.cmd;
    assign ba        = head.ba;
    assign init_done = (step == ST_DONE) || (step == ST_LOCK && lock_ok);

    // Spacing monitor for mode-register writes
    logic [SP_W-1:0] since_mode;
    always_ff @(posedge clk) begin
        if (rst)
            since_mode <= SP_W'(T_MRD);
        else if (head.cmd == CMD_MODE)
            since_mode <= SP_W'(1);
        else if (since_mode < SP_W'(T_MRD))
            since_mode <= since_mode + 1'b1;
    end

    assert_quiet_before_cke_R1: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (head.cmd == CMD_NOP && !init_done));

    assert_cke_holds_R2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    assert_mode_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (head.cmd == CMD_MODE) |-> (since_mode >= SP_W'(T_MRD)));

    assert_ext_fields_R5: assert property (@(posedge clk) disable iff (rst)
        (head.cmd == CMD_MODE && ba == BA_W'(1)) |-> ((addr & ~(ADDR_W'(1) << BIT_DRV)) == '0));

    // R6 and R8: test bit stays low on every mode write
    assert_mode_test_low_R6: assert property (@(posedge clk) disable iff (rst)
        (head.cmd == CMD_MODE && ba == '0) |-> !addr[BIT_TEST]);

    assert_done_needs_lock_R10: assert property (@(posedge clk) disable iff (rst)
        init_done |-> lock_ok);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && head.cmd == CMD_NOP));
endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

    typedef struct packed {
        logic        cke;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        done;
    } obs_t;

    typedef struct packed {
        int ts, trp, trfc, tmrd, nref, tlock;
    } prm_t;

    localparam prm_t PA = '{ts: 40, trp: 3, trfc: 7, tmrd: 2, nref: 3, tlock: 30};
    localparam prm_t PB = '{ts: 25, trp: 2, trfc: 9, tmrd: 3, nref: 2, tlock: 12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] mode_word = '0;
    logic [12:0] ext_word  = '0;

    logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba;
    logic [12:0] a_addr;
    logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba;
    logic [12:0] b_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ddr_init_seq #(.ADDR_W(13), .T_STABLE(PA.ts), .T_RP(PA.trp), .T_RFC(PA.trfc),
                   .T_MRD(PA.tmrd), .N_REF(PA.nref), .T_DLL_LOCK(PA.tlock)) u_ddr_init_seq (
        .clk(clk), .rst(rst), .mode_word(mode_word), .ext_word(ext_word),
        .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
        .ba(a_ba), .addr(a_addr), .init_done(a_done));

    ddr_init_seq #(.ADDR_W(13), .T_STABLE(PB.ts), .T_RP(PB.trp), .T_RFC(PB.trfc),
                   .T_MRD(PB.tmrd), .N_REF(PB.nref), .T_DLL_LOCK(PB.tlock)) u_ddr_init_seq_alt (
        .clk(clk), .rst(rst), .mode_word(mode_word), .ext_word(ext_word),
        .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
        .ba(b_ba), .addr(b_addr), .init_done(b_done));

    // Reference model: expected outputs in cycle k after reset release
    function automatic obs_t expect_at(input prm_t p, input int k);
        obs_t o;
        int c_p1, c_ext, c_rst, c_p2, c_r0, c_fin, c_done;
        c_p1   = p.ts + 1;
        c_ext  = c_p1 + p.trp;
        c_rst  = c_ext + p.tmrd;
        c_p2   = c_rst + p.tmrd;
        c_r0   = c_p2 + p.trp;
        c_fin  = c_r0 + p.nref * p.trfc;
        c_done = (c_fin + p.tmrd > c_rst + p.tlock) ? c_fin + p.tmrd : c_rst + p.tlock;
        o = '{cke: (k >= p.ts), cmd: 4'b0111, ba: 2'b00, addr: 13'h0, done: (k >= c_done)};
        if (k == c_p1 || k == c_p2) begin
            o.cmd = 4'b0010; o.addr = 13'h0400;
        end else if (k == c_ext) begin
            o.cmd = 4'b0000; o.ba = 2'b01; o.addr = ext_word & 13'h0002;
        end else if (k == c_rst) begin
            o.cmd = 4'b0000; o.addr = (mode_word & ~13'h0180) | 13'h0100;
        end else if (k == c_fin) begin
            o.cmd = 4'b0000; o.addr = mode_word & ~13'h0180;
        end else if (k >= c_r0 && k < c_fin && ((k - c_r0) % p.trfc) == 0) begin
            o.cmd = 4'b0001;
        end
        return o;
    endfunction

    function automatic string tag_at(input prm_t p, input int k);
        int c_rst, c_fin;
        c_rst = p.ts + 1 + p.trp + p.tmrd;
        c_fin = c_rst + p.tmrd + p.trp + p.nref * p.trfc;
        if (k < p.ts)                                   return "R1";
        if (k == p.ts)                                  return "R2";
        if (k == p.ts + 1 || k == c_rst + p.tmrd)       return "R3,R4";
        if (k == c_rst - p.tmrd)                        return "R3,R5";
        if (k == c_rst)                                 return "R3,R6";
        if (k > c_rst + p.tmrd && k < c_fin)            return "R3,R7,R9";
        if (k == c_fin)                                 return "R3,R8";
        return "R9,R10";
    endfunction

    task automatic compare(input string who, input string run, input obs_t act, input obs_t exp_v,
                           input string tag, input int k);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s %s cycle %0d: actual cke=%b cmd=%b ba=%b addr=%h done=%b expected cke=%b cmd=%b ba=%b addr=%h done=%b",
                     tag, run, who, k, act.cke, act.cmd, act.ba, act.addr, act.done,
                     exp_v.cke, exp_v.cmd, exp_v.ba, exp_v.addr, exp_v.done);
        end
    endtask

    task automatic do_reset();
        obs_t exp_rst;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        exp_rst = '{cke: 1'b0, cmd: 4'b0111, ba: 2'b00, addr: 13'h0, done: 1'b0};
        // R1: state while reset is held
        compare("A", "reset", {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done}, exp_rst, "R1", -1);
        compare("B", "reset", {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done}, exp_rst, "R1", -1);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic run_cycles(input int n, input string run);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare("A", run, {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done},
                    expect_at(PA, k), tag_at(PA, k), k);
            compare("B", run, {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done},
                    expect_at(PB, k), tag_at(PB, k), k);
        end
    endtask

    initial begin
        // Run 1: typical mode word, plain extended word
        mode_word = 13'h0032;
        ext_word  = 13'h0000;
        do_reset();
        run_cycles(100, "run1");

        // Run 2: all-ones words exercise forced bits and masking (R5, R6, R8)
        mode_word = 13'h1FFF;
        ext_word  = 13'h1FFF;
        do_reset();
        run_cycles(100, "run2");

        // Run 3: reset in the middle of the refresh phase, then full restart (R11)
        mode_word = 13'h0A5A;
        ext_word  = 13'h0002;
        do_reset();
        run_cycles(60, "run3");
        do_reset();
        run_cycles(100, "R11-restart");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule